// File: doc/BRIEF.md
# Edge-Selectable Interrupt Latch Bank

This block gathers interrupt events from four digital inputs: two isolated and two plain. Each input is first brought into the clock domain through a flop chain. Then an edge detector looks for the active edge, which is chosen per input. When that edge arrives and the input is enabled, the detector sets a sticky flag. Software clears a flag by writing a one to its bit in a clear register.

A small synchronous register port holds three control registers: enable, edge select and clear. A fourth register reports status. A single request line goes high while any enabled flag is pending. The host bus bridge and any input debouncing live outside this block.

Top module: `edge_irq_bank`

## Requirements
- R1: Source bit positions, from bit 0 upward, are: isolated input 0, isolated input 1, plain input 0, plain input 1. The same positions are used in every register.
- R2: The enable register sits at offset 0x08. A 1 in a bit enables that source. Only bits 3:0 are stored, and it reads back at 0x08 with zeros above bit 3.
- R3: The edge select register sits at offset 0x0C. A 0 in a bit selects the rising edge and a 1 selects the falling edge. Only bits 3:0 are stored, and it reads back at 0x0C.
- R4: Writing offset 0x10 clears the flag of every source whose data bit is 1. A 0 bit leaves that flag unchanged.
- R5: Once set, a flag stays at 1 until it is cleared. Later edges in either direction do not alter it.
- R6: A disabled source never sets its flag. Disabling a source leaves an already set flag at 1.
- R7: When a clear write and a qualifying edge for the same source land in the same clock, the flag ends up at 1.
- R8: Offset 0x14 returns the four flags in bits 3:0 with zeros above. Any offset other than 0x08, 0x0C or 0x14 reads as 0.
- R9: The request output is 1 exactly when some flag is set and its enable bit is 1.
- R10: After reset, all enables are 0, all sources select the rising edge, all flags are 0 and the request output is 0.
- R11: An edge detected in the same clock as a write to the edge select register is ignored for every source.
- R12: An input change is seen after two synchroniser flops plus one history flop. The flag rises on the third rising clock edge after the input changes, and it is still 0 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_in | input | 2 | Isolated asynchronous inputs |
| gpi_in | input | 2 | Plain asynchronous inputs |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: two isolated and two plain inputs, with a two-flop synchroniser. This configuration is small enough to sweep every combination of source, polarity and enable. Each run takes one pulse in the active direction and then one in the opposite direction. Directed sequences then place a clear write, or an edge select write, in exactly the clock where a detected edge would set a flag. This checks the same-cycle priority and the history reset at cycle accuracy.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h14;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic wr_enable;
        logic wr_edge;
        logic wr_clear;
    } reg_wr_s;

    function automatic logic edge_hit(logic cur, logic prev, edge_sel_e sel);
        return (sel == EDGE_FALL) ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/irq_chan.sv
module irq_chan
    import irq_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_in,
    input  logic      en,
    input  edge_sel_e sel,
    input  logic      sel_wr,
    input  logic      clr,
    output logic      flag
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   hit;

    // Masked while the edge select register is written (history reset).
    assign hit  = en & ~sel_wr & edge_hit(sync_q[TOP], prev_q, sel);
    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], async_in};
            prev_q <= sync_q[TOP];
            flag_q <= (flag_q & ~clr) | hit;
        end
    end

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr |=> flag_q);
    p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
        clr && !hit |=> !flag_q);
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !en && !flag_q |=> !flag_q);
    p_selwr_mask_r11: assert property (@(posedge clk) disable iff (rst)
        sel_wr && !flag_q |=> !flag_q);

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_bank_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   flags,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   sel_q,
    output logic              sel_wr,
    output logic [NSRC-1:0]   clr,
    output logic [DATA_W-1:0] rdata
);

    reg_wr_s dec;

    always_comb begin
        dec.wr_enable = wr && (addr == OFS_ENABLE);
        dec.wr_edge   = wr && (addr == OFS_EDGE);
        dec.wr_clear  = wr && (addr == OFS_CLEAR);
    end

    assign sel_wr = dec.wr_edge;
    assign clr    = dec.wr_clear ? wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (dec.wr_enable) en_q  <= wdata[NSRC-1:0];
            if (dec.wr_edge)   sel_q <= wdata[NSRC-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_ENABLE: rdata[NSRC-1:0] = en_q;
            OFS_EDGE:   rdata[NSRC-1:0] = sel_q;
            OFS_STATUS: rdata[NSRC-1:0] = flags;
            default:    rdata = '0;
        endcase
    end

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !dec.wr_enable |=> $stable(en_q));
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !dec.wr_edge |=> $stable(sel_q));

endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NISO        = 2,
    parameter int NGPI        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NISO-1:0]   iso_in,
    input  logic [NGPI-1:0]   gpi_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int NSRC = NISO + NGPI;

    logic [NSRC-1:0] src;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] sel_q;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] flags;
    logic            sel_wr;

    // Isolated inputs occupy the low bits, plain inputs follow.
    assign src = {gpi_in, iso_in};

    irq_regfile #(.NSRC(NSRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .flags  (flags),
        .en_q   (en_q),
        .sel_q  (sel_q),
        .sel_wr (sel_wr),
        .clr    (clr),
        .rdata  (reg_rdata)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_chan
        irq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .async_in (src[i]),
            .en       (en_q[i]),
            .sel      (edge_sel_e'(sel_q[i])),
            .sel_wr   (sel_wr),
            .clr      (clr[i]),
            .flag     (flags[i])
        );
    end

    assign irq = |(flags & en_q);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!irq && flags == '0 && en_q == '0));

endmodule

// File: tb/edge_irq_bank_tb.sv
module edge_irq_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] iso_in = '0;
    logic [1:0] gpi_in = '0;
    logic [4:0] reg_addr = 5'h14;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_irq_bank u_dut (
        .clk(clk), .rst(rst), .iso_in(iso_in), .gpi_in(gpi_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(int idx, logic v);
        logic [3:0] s;
        s = {gpi_in, iso_in};
        s[idx] = v;
        {gpi_in, iso_in} = s;
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 5'h14;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; #1;
        d = reg_rdata;
        reg_addr = 5'h14;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Drive one input change and check the R12 timing on the status bit.
    task automatic pulse(int idx, logic v, logic exp_flag, logic prior);
        @(negedge clk);
        set_src(idx, v);
        @(posedge clk); @(posedge clk); #1;
        chk("R12 flag not yet set", reg_rdata[idx], prior);
        @(posedge clk); #1;
        chk("R12 flag after sync", reg_rdata[idx], exp_flag);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 status", reg_rdata, 0);
        chk("R10 irq", irq, 0);
        rd(5'h08, d); chk("R10 enable", d, 0);
        rd(5'h0C, d); chk("R10 edge rising", d, 0);
        // R2/R3 readback with upper bits dropped
        wr(5'h08, 8'hFF); rd(5'h08, d); chk("R2 enable readback", d, 8'h0F);
        wr(5'h0C, 8'hA5); rd(5'h0C, d); chk("R3 edge readback", d, 8'h05);
        // R8 unmapped offsets
        rd(5'h00, d); chk("R8 unmapped 0x00", d, 0);
        rd(5'h10, d); chk("R8 clear reads 0", d, 0);
        wr(5'h08, 8'h00);

        // Sweep: source x polarity x enable (R1, R2, R3, R5, R6, R9, R4)
        for (int en = 0; en < 2; en++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int s = 0; s < 4; s++) begin
                    logic idle;
                    idle = (pol == 1);
                    wr(5'h08, 8'h00);
                    wr(5'h0C, pol ? 8'h0F : 8'h00);
                    @(negedge clk);
                    iso_in = {2{idle}}; gpi_in = {2{idle}};
                    settle();
                    wr(5'h10, 8'h0F);
                    wr(5'h08, en ? (8'h1 << s) : 8'h00);
                    pulse(s, ~idle, logic'(en), 1'b0);
                    chk("R1 status bit position", reg_rdata, en ? (1 << s) : 0);
                    chk("R9 irq", irq, en);
                    pulse(s, idle, logic'(en), logic'(en));
                    chk("R5 sticky after opposite edge", reg_rdata, en ? (1 << s) : 0);
                    pulse(s, ~idle, logic'(en), logic'(en));
                    chk("R5 sticky after second edge", reg_rdata, en ? (1 << s) : 0);
                    wr(5'h08, 8'h00); #1;
                    chk("R6 disable keeps flag", reg_rdata, en ? (1 << s) : 0);
                    chk("R9 irq off when disabled", irq, 0);
                    wr(5'h10, 8'h00); #1;
                    chk("R4 zero write no effect", reg_rdata, en ? (1 << s) : 0);
                    wr(5'h10, 8'h1 << s); #1;
                    chk("R4 clear", reg_rdata, 0);
                end
            end
        end

        // R7: clear coinciding with a qualifying edge on source 0
        wr(5'h0C, 8'h00);
        @(negedge clk); iso_in = '0; gpi_in = '0;
        settle();
        wr(5'h10, 8'h0F);
        wr(5'h08, 8'h01);
        pulse(0, 1'b1, 1'b1, 1'b0);
        @(negedge clk); iso_in[0] = 1'b0;
        settle();
        @(negedge clk); iso_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_addr = 5'h10; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(posedge clk); #1; reg_wr = 1'b0; reg_addr = 5'h14; #1;
        chk("R7 edge beats clear", reg_rdata[0], 1);
        chk("R9 irq with pending", irq, 1);

        // R11: edge select write in the detection cycle masks the edge
        wr(5'h10, 8'h0F);
        @(negedge clk); iso_in[0] = 1'b0;
        settle();
        wr(5'h10, 8'h0F);
        @(negedge clk); iso_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_addr = 5'h0C; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(posedge clk); #1; reg_wr = 1'b0; reg_addr = 5'h14;
        settle();
        chk("R11 edge masked by select write", reg_rdata[0], 0);
        chk("R11 no irq", irq, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule